// File: doc/BRIEF.md
# Multi-Pixel Raster Timing Generator

This block produces the raster timing for a streaming video input that moves several pixels on every clock. It runs on the stream's own clock and keeps two counters: a horizontal position that grows by a fixed step on each clock, and a line counter that advances each time the horizontal position wraps. From these two counters it decodes horizontal blanking, horizontal sync, vertical blanking and vertical sync. It also gives a one-clock start-of-frame marker and a one-clock end-of-line marker, and it brings both positions out.

All horizontal values are written in horizontal units, not in clocks. A unit is normally one pixel. When the pair-unit format is chosen (4:2:0 data at 12 bits), a unit is two pixels. The step per clock is then the pixels-in-parallel count in the normal format, or half of it in the pair format. So with two pixels per clock and a line total of 2200, a line takes 1100 clocks. Vertical sync does not simply switch at line boundaries: it turns on at a programmable horizontal position of its first line and turns off at a programmable horizontal position of its last line.

Software writes a full parameter set in one strobe, together with the format flag. A set with a misaligned horizontal value is refused and the block raises an error pulse. An accepted set waits until the next frame boundary, so no frame ever mixes two sets. After reset the generator stays idle until the first set is accepted.

Top module: `mpix_raster_gen`

## Requirements
- R1: From reset until the first accepted write, every strobe (hsync, vsync, hblank, vblank, sof, eol) is low and hpos and vpos read 0.
- R2: A write is refused when any of the six horizontal values is not a whole multiple of PIP, or when the line total or the frame line count is zero. A refused write pulses cfg_err high for exactly the one clock after the write and leaves the running timing and the waiting set untouched.
- R3: An accepted write made while idle starts the raster two clocks after the write edge, with sof at position (0,0). An accepted write made while running takes effect at the first clock of the next frame. If a second write lands on the same clock as a load, the load uses the older set and the newer set waits for the following frame.
- R4: While running, hpos grows by the step on each clock. The step is PIP in pixel units, or PIP/2 (at least 1) in pair units. A line lasts h_total/step clocks.
- R5: eol is high on the last clock of a line, which is the clock where hpos + step >= h_total. On the next clock hpos is 0 and vpos has grown by one, or returns to 0 after line v_total-1.
- R6: sof is high for exactly one clock per frame, at hpos 0 and vpos 0.
- R7: hblank is high while hpos < h_blank_end. hsync is high while h_sync_start <= hpos < h_sync_end.
- R8: vblank is high on every clock of lines with vpos < v_blank_end.
- R9: vsync is high from position (v_sync_start line, vs_h_on), included, to position (v_sync_end line, vs_h_off), excluded. Positions are ordered by line first, then by hpos.
- R10: The format flag cfg_pair_units (1 = pair units) is captured with the write and changes the step only when its set is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-clock strobe that offers a full parameter set |
| cfg_pair_units | input | 1 | 1 selects pair units (4:2:0, 12-bit), 0 selects pixel units |
| cfg_h_total | input | HW | Line length in horizontal units |
| cfg_h_blank_end | input | HW | First position after horizontal blanking |
| cfg_h_sync_start | input | HW | First position of horizontal sync |
| cfg_h_sync_end | input | HW | First position after horizontal sync |
| cfg_vs_h_on | input | HW | Horizontal position where vertical sync turns on |
| cfg_vs_h_off | input | HW | Horizontal position where vertical sync turns off |
| cfg_v_total | input | VW | Lines per frame |
| cfg_v_blank_end | input | VW | First line after vertical blanking |
| cfg_v_sync_start | input | VW | Line on which vertical sync turns on |
| cfg_v_sync_end | input | VW | Line on which vertical sync turns off |
| cfg_err | output | 1 | Pulse one clock after a refused write |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| sof | output | 1 | Start-of-frame marker |
| eol | output | 1 | End-of-line marker |
| hpos | output | HW | Current horizontal position in units |
| vpos | output | VW | Current line |

## Verification
A wrong step or a wrong wrap compare shows up on hpos within one clock, and it moves eol and every horizontal strobe along with it. A fault in the line counter or in the frame-boundary load shows up at the next line or frame edge: vpos, sof, vblank and vsync slip, or a new set appears in the middle of a frame. The bench compares every output on every clock against an independent model of the positions, so the first wrong cycle is caught. Refused writes are checked through cfg_err and through the timing that keeps running unchanged.

// File: rtl/mpix_raster_pkg.sv
package mpix_raster_pkg;

   // Indices into the horizontal parameter bundle
   localparam int unsigned N_HPARAM    = 6;
   localparam int unsigned HI_TOTAL    = 0;
   localparam int unsigned HI_BLK_END  = 1;
   localparam int unsigned HI_SYN_BEG  = 2;
   localparam int unsigned HI_SYN_END  = 3;
   localparam int unsigned HI_VS_ON    = 4;
   localparam int unsigned HI_VS_OFF   = 5;

   // Indices into the vertical parameter bundle
   localparam int unsigned N_VPARAM    = 4;
   localparam int unsigned VI_TOTAL    = 0;
   localparam int unsigned VI_BLK_END  = 1;
   localparam int unsigned VI_SYN_BEG  = 2;
   localparam int unsigned VI_SYN_END  = 3;

   typedef enum logic {
      UNIT_PIXEL = 1'b0,
      UNIT_PAIR  = 1'b1
   } unit_mode_e;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

   // Step in horizontal units per clock for a given mode
   function automatic int unsigned unit_step(input int unsigned pip, input bit pair);
      if (!pair)   return pip;
      if (pip > 1) return pip / 2;
      return 1;
   endfunction

endpackage

// File: rtl/mpix_cfg_stage.sv
module mpix_cfg_stage
   import mpix_raster_pkg::*;
#(
   parameter int unsigned HW  = 14,
   parameter int unsigned VW  = 13,
   parameter int unsigned PIP = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr,
   input  logic                             fmt_in,
   input  logic [N_HPARAM-1:0][HW-1:0]      h_in,
   input  logic [N_VPARAM-1:0][VW-1:0]      v_in,
   input  logic                             frame_end,
   output logic [N_HPARAM-1:0][HW-1:0]      act_h,
   output logic [N_VPARAM-1:0][VW-1:0]      act_v,
   output unit_mode_e                       act_mode,
   output logic                             running,
   output logic                             err
);

   localparam int unsigned ALN_BITS = $clog2(PIP);

   logic [N_HPARAM-1:0]             aligned;
   logic                            totals_ok;
   logic                            wr_ok;
   logic                            wr_bad;
   logic                            load;
   logic                            pend_vld;
   logic [N_HPARAM-1:0][HW-1:0]     pend_h;
   logic [N_VPARAM-1:0][VW-1:0]     pend_v;
   unit_mode_e                      pend_mode;

   // One alignment test per horizontal parameter
   for (genvar gi = 0; gi < N_HPARAM; gi++) begin : g_align
      if (ALN_BITS == 0) begin : g_any
         assign aligned[gi] = 1'b1;
      end else begin : g_low
         assign aligned[gi] = (h_in[gi][ALN_BITS-1:0] == '0);
      end
   end

   assign totals_ok = (h_in[HI_TOTAL] != '0) && (v_in[VI_TOTAL] != '0);
   assign wr_ok     = wr && (&aligned) && totals_ok;
   assign wr_bad    = wr && !((&aligned) && totals_ok);
   assign load      = pend_vld && (!running || frame_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_h    <= '0;
         pend_v    <= '0;
         pend_mode <= UNIT_PIXEL;
         act_h     <= '0;
         act_v     <= '0;
         act_mode  <= UNIT_PIXEL;
         running   <= 1'b0;
         err       <= 1'b0;
      end else begin
         err <= wr_bad;
         if (load) begin
            act_h    <= pend_h;
            act_v    <= pend_v;
            act_mode <= pend_mode;
            running  <= 1'b1;
         end
         if (wr_ok) begin
            pend_h    <= h_in;
            pend_v    <= v_in;
            pend_mode <= unit_mode_e'(fmt_in);
            pend_vld  <= 1'b1;
         end else if (load) begin
            pend_vld  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mpix_raster_cnt.sv
module mpix_raster_cnt
   import mpix_raster_pkg::*;
#(
   parameter int unsigned HW  = 14,
   parameter int unsigned VW  = 13,
   parameter int unsigned PIP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            running,
   input  unit_mode_e      mode,
   input  logic [HW-1:0]   h_total,
   input  logic [VW-1:0]   v_total,
   output logic [HW-1:0]   hpos,
   output logic [VW-1:0]   vpos,
   output logic [HW-1:0]   step,
   output logic            line_end,
   output logic            frame_end
);

   localparam int unsigned STEP_PIX  = unit_step(PIP, 1'b0);
   localparam int unsigned STEP_PAIR = unit_step(PIP, 1'b1);

   logic [HW:0]   h_sum;
   logic          last_line;

   // The step variant is fixed by PIP; only the mode picks at run time
   if (STEP_PIX == STEP_PAIR) begin : g_step_same
      assign step = HW'(STEP_PIX);
   end else begin : g_step_sel
      assign step = (mode == UNIT_PAIR) ? HW'(STEP_PAIR) : HW'(STEP_PIX);
   end

   assign h_sum     = {1'b0, hpos} + {1'b0, step};
   assign line_end  = running && (h_sum >= {1'b0, h_total});
   assign last_line = (vpos == (v_total - VW'(1)));
   assign frame_end = line_end && last_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hpos <= '0;
         vpos <= '0;
      end else if (!running) begin
         hpos <= '0;
         vpos <= '0;
      end else if (line_end) begin
         hpos <= '0;
         vpos <= last_line ? '0 : vpos + VW'(1);
      end else begin
         hpos <= h_sum[HW-1:0];
      end
   end

endmodule

// File: rtl/mpix_raster_dec.sv
module mpix_raster_dec
   import mpix_raster_pkg::*;
#(
   parameter int unsigned HW = 14,
   parameter int unsigned VW = 13
) (
   input  logic                          running,
   input  logic [HW-1:0]                 hpos,
   input  logic [VW-1:0]                 vpos,
   input  logic [N_HPARAM-1:0][HW-1:0]   act_h,
   input  logic [N_VPARAM-1:0][VW-1:0]   act_v,
   output logic                          hblank,
   output logic                          hsync,
   output logic                          vblank,
   output logic                          vsync,
   output logic                          sof
);

   logic vs_past_on;
   logic vs_before_off;

   // Vertical sync window is ordered by line first, then by position
   always_comb begin
      vs_past_on    = (vpos > act_v[VI_SYN_BEG]) ||
                      ((vpos == act_v[VI_SYN_BEG]) && (hpos >= act_h[HI_VS_ON]));
      vs_before_off = (vpos < act_v[VI_SYN_END]) ||
                      ((vpos == act_v[VI_SYN_END]) && (hpos < act_h[HI_VS_OFF]));
   end

   always_comb begin
      hblank = running && (hpos < act_h[HI_BLK_END]);
      hsync  = running && (hpos >= act_h[HI_SYN_BEG]) && (hpos < act_h[HI_SYN_END]);
      vblank = running && (vpos < act_v[VI_BLK_END]);
      vsync  = running && vs_past_on && vs_before_off;
      sof    = running && (hpos == '0) && (vpos == '0);
   end

endmodule

// File: rtl/mpix_raster_gen.sv
module mpix_raster_gen
   import mpix_raster_pkg::*;
#(
   parameter int unsigned HW  = 14,
   parameter int unsigned VW  = 13,
   parameter int unsigned PIP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic            cfg_pair_units,
   input  logic [HW-1:0]   cfg_h_total,
   input  logic [HW-1:0]   cfg_h_blank_end,
   input  logic [HW-1:0]   cfg_h_sync_start,
   input  logic [HW-1:0]   cfg_h_sync_end,
   input  logic [HW-1:0]   cfg_vs_h_on,
   input  logic [HW-1:0]   cfg_vs_h_off,
   input  logic [VW-1:0]   cfg_v_total,
   input  logic [VW-1:0]   cfg_v_blank_end,
   input  logic [VW-1:0]   cfg_v_sync_start,
   input  logic [VW-1:0]   cfg_v_sync_end,
   output logic            cfg_err,
   output logic            hsync,
   output logic            vsync,
   output logic            hblank,
   output logic            vblank,
   output logic            sof,
   output logic            eol,
   output logic [HW-1:0]   hpos,
   output logic [VW-1:0]   vpos
);

   initial begin
      assert (is_pow2(PIP)) else $error("PIP must be a power of two");
      assert (HW > $clog2(PIP) + 1) else $error("HW too narrow for PIP");
      assert (VW >= 2) else $error("VW too narrow");
   end

   logic [N_HPARAM-1:0][HW-1:0]   h_bundle;
   logic [N_VPARAM-1:0][VW-1:0]   v_bundle;
   logic [N_HPARAM-1:0][HW-1:0]   act_h;
   logic [N_VPARAM-1:0][VW-1:0]   act_v;
   unit_mode_e                    act_mode;
   logic                          running;
   logic                          frame_end;
   logic [HW-1:0]                 step_units;
   logic [VW-1:0]                 act_vtotal;

   always_comb begin
      h_bundle[HI_TOTAL]   = cfg_h_total;
      h_bundle[HI_BLK_END] = cfg_h_blank_end;
      h_bundle[HI_SYN_BEG] = cfg_h_sync_start;
      h_bundle[HI_SYN_END] = cfg_h_sync_end;
      h_bundle[HI_VS_ON]   = cfg_vs_h_on;
      h_bundle[HI_VS_OFF]  = cfg_vs_h_off;
      v_bundle[VI_TOTAL]   = cfg_v_total;
      v_bundle[VI_BLK_END] = cfg_v_blank_end;
      v_bundle[VI_SYN_BEG] = cfg_v_sync_start;
      v_bundle[VI_SYN_END] = cfg_v_sync_end;
   end

   assign act_vtotal = act_v[VI_TOTAL];

   mpix_cfg_stage #(.HW(HW), .VW(VW), .PIP(PIP)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .fmt_in    (cfg_pair_units),
      .h_in      (h_bundle),
      .v_in      (v_bundle),
      .frame_end (frame_end),
      .act_h     (act_h),
      .act_v     (act_v),
      .act_mode  (act_mode),
      .running   (running),
      .err       (cfg_err)
   );

   mpix_raster_cnt #(.HW(HW), .VW(VW), .PIP(PIP)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (running),
      .mode      (act_mode),
      .h_total   (act_h[HI_TOTAL]),
      .v_total   (act_vtotal),
      .hpos      (hpos),
      .vpos      (vpos),
      .step      (step_units),
      .line_end  (eol),
      .frame_end (frame_end)
   );

   mpix_raster_dec #(.HW(HW), .VW(VW)) u_dec (
      .running (running),
      .hpos    (hpos),
      .vpos    (vpos),
      .act_h   (act_h),
      .act_v   (act_v),
      .hblank  (hblank),
      .hsync   (hsync),
      .vblank  (vblank),
      .vsync   (vsync),
      .sof     (sof)
   );

endmodule

// File: rtl/mpix_raster_chk.sv
module mpix_raster_chk #(
   parameter int unsigned HW = 14,
   parameter int unsigned VW = 13
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_wr,
   input logic            cfg_err,
   input logic            running,
   input logic            sof,
   input logic            eol,
   input logic            hsync,
   input logic            vsync,
   input logic            hblank,
   input logic            vblank,
   input logic [HW-1:0]   hpos,
   input logic [VW-1:0]   vpos,
   input logic [HW-1:0]   step,
   input logic [VW-1:0]   vtotal
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !(sof || eol || hsync || vsync || hblank || vblank) && hpos == '0 && vpos == '0)
      else $error("idle outputs not quiet"); // R1

   AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_wr))
      else $error("error pulse without a write"); // R2

   AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) && !$past(eol) |-> hpos == $past(hpos) + $past(step))
      else $error("hpos did not advance by step"); // R4

   AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> hpos == '0)
      else $error("hpos not zero after end of line"); // R5

   AST_VPOS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      eol && (vpos != vtotal - VW'(1)) |=> vpos == $past(vpos) + VW'(1))
      else $error("vpos did not advance"); // R5

   AST_SOF_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(running) && $past(eol) && vpos == '0 |-> sof)
      else $error("no sof after frame wrap"); // R6

endmodule

bind mpix_raster_gen mpix_raster_chk #(.HW(HW), .VW(VW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_wr  (cfg_wr),
   .cfg_err (cfg_err),
   .running (running),
   .sof     (sof),
   .eol     (eol),
   .hsync   (hsync),
   .vsync   (vsync),
   .hblank  (hblank),
   .vblank  (vblank),
   .hpos    (hpos),
   .vpos    (vpos),
   .step    (step_units),
   .vtotal  (act_vtotal)
);

// File: tb/tb_mpix_raster_gen.sv
module tb_mpix_raster_gen;

   localparam int CLK_PERIOD = 10;
   localparam int HW  = 14;
   localparam int VW  = 13;
   localparam int PIP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic cfg_pair_units = 1'b0;
   logic [HW-1:0] cfg_h_total = '0, cfg_h_blank_end = '0, cfg_h_sync_start = '0;
   logic [HW-1:0] cfg_h_sync_end = '0, cfg_vs_h_on = '0, cfg_vs_h_off = '0;
   logic [VW-1:0] cfg_v_total = '0, cfg_v_blank_end = '0;
   logic [VW-1:0] cfg_v_sync_start = '0, cfg_v_sync_end = '0;
   logic cfg_err, hsync, vsync, hblank, vblank, sof, eol;
   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Reference model state
   bit m_run, m_err, m_pvld, m_apair, m_ppair;
   int m_h, m_v;
   int m_ah[6], m_av[4], m_ph[6], m_pv[4];

   mpix_raster_gen #(.HW(HW), .VW(VW), .PIP(PIP)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int step_of(bit pair);
      if (!pair) return PIP;
      return (PIP > 1) ? PIP / 2 : 1;
   endfunction

   task automatic cmp(string what, string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_outputs();
      int st;
      bit on, off;
      st  = step_of(m_apair);
      on  = (m_v > m_av[2]) || (m_v == m_av[2] && m_h >= m_ah[4]);
      off = (m_v < m_av[3]) || (m_v == m_av[3] && m_h < m_ah[5]);
      cmp("hpos",   "R4 R10", int'(hpos), m_run ? m_h : 0);
      cmp("vpos",   "R5",     int'(vpos), m_run ? m_v : 0);
      cmp("eol",    "R5",     int'(eol),  int'(m_run && (m_h + st >= m_ah[0])));
      cmp("sof",    "R6 R3",  int'(sof),  int'(m_run && m_h == 0 && m_v == 0));
      cmp("hblank", "R7 R1",  int'(hblank), int'(m_run && m_h < m_ah[1]));
      cmp("hsync",  "R7 R1",  int'(hsync),  int'(m_run && m_h >= m_ah[2] && m_h < m_ah[3]));
      cmp("vblank", "R8 R1",  int'(vblank), int'(m_run && m_v < m_av[1]));
      cmp("vsync",  "R9 R1",  int'(vsync),  int'(m_run && on && off));
      cmp("cfg_err","R2",     int'(cfg_err), int'(m_err));
   endtask

   // Effect of the coming clock edge on the model
   task automatic model_step();
      int st;
      bit ok, load, last;
      st = step_of(m_apair);
      ok = (cfg_h_total % PIP == 0) && (cfg_h_blank_end % PIP == 0) &&
           (cfg_h_sync_start % PIP == 0) && (cfg_h_sync_end % PIP == 0) &&
           (cfg_vs_h_on % PIP == 0) && (cfg_vs_h_off % PIP == 0) &&
           (cfg_h_total != 0) && (cfg_v_total != 0);
      last = m_run && (m_h + st >= m_ah[0]) && (m_v == m_av[0] - 1);
      load = m_pvld && (!m_run || last);
      if (m_run) begin
         if (m_h + st >= m_ah[0]) begin
            m_h = 0;
            m_v = (m_v == m_av[0] - 1) ? 0 : m_v + 1;
         end else begin
            m_h = m_h + st;
         end
      end
      if (load) begin
         m_ah = m_ph; m_av = m_pv; m_apair = m_ppair;
         m_run = 1'b1; m_pvld = 1'b0;
      end
      if (cfg_wr && ok) begin
         m_ph = '{int'(cfg_h_total), int'(cfg_h_blank_end), int'(cfg_h_sync_start),
                  int'(cfg_h_sync_end), int'(cfg_vs_h_on), int'(cfg_vs_h_off)};
         m_pv = '{int'(cfg_v_total), int'(cfg_v_blank_end), int'(cfg_v_sync_start),
                  int'(cfg_v_sync_end)};
         m_ppair = cfg_pair_units;
         m_pvld  = 1'b1;
      end
      m_err = cfg_wr && !ok;
   endtask

   task automatic tick(bit wr);
      cfg_wr = wr;
      model_step();
      @(negedge clk);
      check_outputs();
      cfg_wr = 1'b0;
   endtask

   task automatic set_cfg(int ht, int hbe, int hss, int hse, int von, int voff,
                          int vt, int vbe, int vss, int vse, bit pair);
      cfg_h_total = HW'(ht); cfg_h_blank_end = HW'(hbe);
      cfg_h_sync_start = HW'(hss); cfg_h_sync_end = HW'(hse);
      cfg_vs_h_on = HW'(von); cfg_vs_h_off = HW'(voff);
      cfg_v_total = VW'(vt); cfg_v_blank_end = VW'(vbe);
      cfg_v_sync_start = VW'(vss); cfg_v_sync_end = VW'(vse);
      cfg_pair_units = pair;
   endtask

   function automatic int al(int lim);
      return PIP * $urandom_range(0, lim / PIP);
   endfunction

   task automatic rand_cfg();
      int ht, hss, vt, vss;
      ht  = PIP * $urandom_range(3, 24);
      hss = al(ht);
      vt  = $urandom_range(2, 9);
      vss = $urandom_range(0, vt - 1);
      set_cfg(ht, al(ht), hss, hss + al(ht - hss), al(ht), al(ht),
              vt, $urandom_range(0, vt), vss, $urandom_range(vss, vt), 1'($urandom_range(0, 1)));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2024));
      m_run = 0; m_err = 0; m_pvld = 0; m_apair = 0; m_ppair = 0; m_h = 0; m_v = 0;
      m_ah = '{0, 0, 0, 0, 0, 0}; m_av = '{0, 0, 0, 0};
      m_ph = m_ah; m_pv = m_av;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs();                       // R1 reset state
      repeat (5) tick(1'b0);                 // R1 idle holds

      // R2: misaligned and zero totals are refused while idle
      set_cfg(21, 4, 2, 4, 0, 2, 5, 1, 0, 1, 1'b0);
      tick(1'b1); tick(1'b0); tick(1'b0);
      set_cfg(0, 0, 0, 0, 0, 0, 5, 1, 0, 1, 1'b0);
      tick(1'b1); tick(1'b0);
      set_cfg(20, 4, 2, 4, 0, 2, 0, 1, 0, 1, 1'b0);
      tick(1'b1); tick(1'b0);

      // R3: write then another on the load clock; the first runs first
      set_cfg(20, 6, 2, 4, 4, 10, 6, 2, 1, 3, 1'b0);
      tick(1'b1);
      set_cfg(16, 4, 8, 12, 6, 2, 4, 1, 2, 3, 1'b1);  // R10 pair units queued
      tick(1'b1);
      repeat (200) tick(1'b0);

      // R2: refused write while running leaves timing untouched
      set_cfg(15, 3, 2, 4, 0, 2, 5, 1, 0, 1, 1'b0);
      tick(1'b1);
      repeat (100) tick(1'b0);

      // Random sets written at random points of a frame
      for (int k = 0; k < 40; k++) begin
         rand_cfg();
         if ($urandom_range(0, 5) == 0) cfg_h_blank_end = cfg_h_blank_end | HW'(1);
         tick(1'b1);
         repeat ($urandom_range(300, 1500)) tick(1'b0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule